// File: doc/BRIEF.md
# Timer repetition counter update generator

This block thins out the update events of a PWM timer. The main counter reports each end of a period with a one-cycle pulse: `ovf_i` for an overflow and `unf_i` for an underflow. An internal 8-bit down-counter consumes these pulses. An update event is issued only when the down-counter is at zero as a counted pulse arrives. On that event the down-counter reloads from the repetition register and starts a new interval.

A repetition value `REP` therefore produces one update every `REP+1` counted events.
- In edge-aligned mode (`center_i` = 0) only overflows are counted, so an update comes every `REP+1` PWM periods.
- In center-aligned mode (`center_i` = 1) overflows and underflows are both counted, so an update comes every `REP+1` half periods.

Software writes the repetition register through a simple write port. The value it writes reaches the down-counter only on the next update event. The update rate therefore changes exactly on an interval boundary. Each update can also raise an interrupt request, gated by an enable input.

Top module: `rcu_top`

## Requirements
- R1: After reset, `rd_data_o` is 0, `upd_o` is 0 and `irq_o` is 0. The down-counter is at 0, so the first counted event produces an update.
- R2: A write with `wr_en_i` = 1 stores `wr_data_i[7:0]` into the register. From the cycle after the write, `rd_data_o[7:0]` shows the stored value and `rd_data_o[15:8]` reads 0, whatever the written upper bits were.
- R3: With a reload value of 0, every counted event produces an update.
- R4: With `center_i` = 0, only `ovf_i` is counted and `unf_i` has no effect. An update occurs on every `REP+1`-th overflow.
- R5: With `center_i` = 1, `ovf_i` and `unf_i` are both counted. A cycle with both high counts once.
- R6: A register write leaves the running interval unchanged. The reload on each update uses the register value held before that cycle, so a write in the same cycle as an update takes effect one interval later.
- R7: `upd_o` is high for exactly the one clock cycle that follows the edge at which the update-producing event was sampled.
- R8: `irq_o` equals `upd_o` when `irq_en_i` was 1 in the event cycle, and is 0 otherwise.
- R9: In cycles with no counted event, the down-counter holds its value and no update is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data; bits 7:0 are used |
| rd_data_o | output | 16 | Register readback, upper byte 0 |
| ovf_i | input | 1 | Main counter overflow pulse |
| unf_i | input | 1 | Main counter underflow pulse |
| center_i | input | 1 | 1 = center-aligned, count both pulses |
| irq_en_i | input | 1 | Update interrupt enable |
| upd_o | output | 1 | Update event pulse |
| irq_o | output | 1 | Update interrupt request pulse |

## Verification
A wrong down-counter value shows only as an update pulse that arrives early or late. It first becomes visible at the next counted event that should, or should not, have fired. That can be up to `REP+1` events after the fault, so the bench compares `upd_o` against a reference model on every cycle. A reload from the freshly written value instead of the old one shifts exactly one interval. The bench exposes this by changing the register in the middle of an interval and in the same cycle as an update. Readback faults show one cycle after a write.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int unsigned REP_W_DEF = 8;
  localparam int unsigned BUS_W_DEF = 16;
endpackage

// File: rtl/rcu_reg.sv
module rcu_reg #(
  parameter int unsigned REP_W = rcu_pkg::REP_W_DEF,
  parameter int unsigned BUS_W = rcu_pkg::BUS_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic [REP_W-1:0] rep_o,
  output logic [BUS_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = BUS_W - REP_W;

  logic [REP_W-1:0] rep_q;
  logic             unused_hi;

  assign unused_hi = ^wr_data_i[BUS_W-1:REP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rep_q <= '0;
    else if (wr_en_i) rep_q <= wr_data_i[REP_W-1:0];
  end

  assign rep_o     = rep_q;
  assign rd_data_o = {{PAD_W{1'b0}}, rep_q};

  AST_WR_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rep_o == $past(wr_data_i[REP_W-1:0])); // R2
  AST_NO_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rep_o)); // R6
endmodule

// File: rtl/rcu_evsel.sv
module rcu_evsel (
  input  logic ovf_i,
  input  logic unf_i,
  input  logic center_i,
  output logic ev_o
);
  // edge-aligned: overflow marks the period end; center-aligned: both halves
  assign ev_o = ovf_i | (center_i & unf_i);

  always_comb begin
    AST_EDGE_IGNORES_UNF: assert (center_i || ev_o == ovf_i); // R4
  end
endmodule

// File: rtl/rcu_downcnt.sv
module rcu_downcnt #(
  parameter int unsigned REP_W = rcu_pkg::REP_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic [REP_W-1:0] rep_i,
  input  logic             irq_en_i,
  output logic             upd_o,
  output logic             irq_o
);
  logic [REP_W-1:0] cnt_q;
  logic             fire;
  logic             upd_q;
  logic             irq_q;

  assign fire = ev_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      upd_q <= fire;
      irq_q <= fire & irq_en_i;
      if (ev_i) begin
        if (fire) cnt_q <= rep_i;
        else      cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign upd_o = upd_q;
  assign irq_o = irq_q;

  AST_RELOAD_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> cnt_q == $past(rep_i)); // R6
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1 && !upd_o); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i |=> $stable(cnt_q) && !upd_o); // R9
  AST_UPD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(ev_i)); // R7
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> upd_o && $past(irq_en_i)); // R8
endmodule

// File: rtl/rcu_top.sv
module rcu_top #(
  parameter int unsigned REP_W = rcu_pkg::REP_W_DEF,
  parameter int unsigned BUS_W = rcu_pkg::BUS_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic [BUS_W-1:0] rd_data_o,
  input  logic             ovf_i,
  input  logic             unf_i,
  input  logic             center_i,
  input  logic             irq_en_i,
  output logic             upd_o,
  output logic             irq_o
);
  logic [REP_W-1:0] rep;
  logic             ev;

  rcu_reg #(.REP_W(REP_W), .BUS_W(BUS_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rep_o     (rep),
    .rd_data_o (rd_data_o)
  );

  rcu_evsel u_evsel (
    .ovf_i    (ovf_i),
    .unf_i    (unf_i),
    .center_i (center_i),
    .ev_o     (ev)
  );

  rcu_downcnt #(.REP_W(REP_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .rep_i    (rep),
    .irq_en_i (irq_en_i),
    .upd_o    (upd_o),
    .irq_o    (irq_o)
  );
endmodule

// File: tb/sim_rcu_top.sv
`timescale 1ns/1ps
module sim_rcu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        ovf = 1'b0, unf = 1'b0, center = 1'b0, irq_en = 1'b0;
  logic        upd, irq;

  int total = 0, bad = 0;
  logic [7:0] m_reg = '0, m_cnt = '0;
  int fires = 0;

  always #2 clk = ~clk;

  rcu_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ovf_i(ovf), .unf_i(unf), .center_i(center),
    .irq_en_i(irq_en), .upd_o(upd), .irq_o(irq)
  );

  function automatic logic counted(logic o, logic u, logic c);
    return o | (c & u);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic w, logic [15:0] d, logic o, logic u,
                      logic c, logic ie);
    logic ev, f;
    @(negedge clk);
    wr_en = w; wr_data = d; ovf = o; unf = u; center = c; irq_en = ie;
    ev = counted(o, u, c);
    f  = ev && (m_cnt == 8'd0);
    if (ev) m_cnt = f ? m_reg : m_cnt - 8'd1;
    if (w) m_reg = d[7:0];
    if (f) fires++;
    @(posedge clk); #1;
    chk({tag, " upd R7"}, upd, f);
    chk({tag, " irq R8"}, irq, f & ie);
    chk({tag, " rd R2"}, rd_data, {8'h00, m_reg});
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog R9 act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("reset R1 rd", rd_data, 0);
    chk("reset R1 upd", upd, 0);
    chk("reset R1 irq", irq, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first counted event fires from the reset count of 0
    step("R1 first", 0, 0, 1, 0, 0, 1);
    // R3: reload 0 -> every event fires
    fires = 0;
    repeat (4) step("R3", 0, 0, 1, 0, 0, 1);
    chk("R3 count", fires, 4);
    // R2: upper bits written are dropped
    step("R2 wr", 1, 16'hA503, 0, 0, 0, 0);
    // R9: idle cycles hold the counter
    repeat (5) step("R9 idle", 0, 0, 0, 0, 0, 0);
    // R4: edge mode, underflows ignored, REP=3 -> every 4th overflow
    step("R4 load", 0, 0, 1, 0, 0, 1);
    fires = 0;
    for (int i = 0; i < 8; i++) begin
      step("R4 unf", 0, 0, 0, 1, 0, 1);
      step("R4 ovf", 0, 0, 1, 0, 0, 1);
    end
    chk("R4 count", fires, 2);
    // R6: mid-interval write 1; old interval of 4 must finish first
    step("R6 a", 0, 0, 1, 0, 0, 0);
    step("R6 wr", 1, 16'h0001, 0, 0, 0, 0);
    fires = 0;
    step("R6 b", 0, 0, 1, 0, 0, 0);
    step("R6 c", 0, 0, 1, 0, 0, 0);
    chk("R6 no early", fires, 0);
    step("R6 d", 0, 0, 1, 0, 0, 0);
    chk("R6 old end", fires, 1);
    step("R6 e", 0, 0, 1, 0, 0, 0);
    step("R6 f", 0, 0, 1, 0, 0, 0);
    chk("R6 new int", fires, 2);
    // R6: write coinciding with an update uses the old value
    step("R6 g", 0, 0, 1, 0, 0, 0);
    step("R6 same", 1, 16'h0004, 1, 0, 0, 0);
    // R5: center mode counts both, both-high counts once
    step("R5 both", 0, 0, 1, 1, 1, 1);
    repeat (10) step("R5 unf", 0, 0, 0, 1, 1, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic w;
      w = ($urandom % 23) == 0;
      step("rand", w, 16'($urandom % 6) | 16'($urandom & 16'hFF00),
           ($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule